// File: doc/BRIEF.md
# Trigger-Synchronized Master/Slave Timer

An up-counting timer with a slave-mode controller and a trigger output. The slave controller watches one selected trigger source. In trigger mode, the first rising edge on that source latches the counter enable on. In gated mode, the enable follows the trigger level. The trigger output can carry the enable to a peer timer. This lets two instances be chained so that a single external rising edge starts both counters.

A synchronization bit delays the local counter by one clock behind its enable. This matches the one-cycle latency a chained peer sees on the trigger path, so a master with the bit set and its slave count in lockstep. The counter can be preloaded while stopped, which fixes an offset between the two timers. An update-generate strobe clears the counter.

Top module: `trig_sync_timer`

## Requirements
- R1: After reset the counter is 0, the enable is 0, the trigger flag is 0 and the trigger output is 0. All mode fields read as 0.
- R2: With slave mode 3'b110 (trigger mode), a rising edge on the selected trigger sets the enable at the next clock edge. The enable then stays 1 when the trigger falls.
- R3: Trigger select 3'b100 picks the external input and 3'b001 picks the peer trigger input. Any other code gives a trigger that is always low, so edges on either input are ignored.
- R4: With output select 3'b001 the trigger output equals the enable. With any other code the trigger output is 0.
- R5: With the sync bit clear, the counter increments on every clock edge at which the enable is already 1. It wraps from all ones to 0.
- R6: With the sync bit set, the counter starts one cycle later than the enable. A slave fed by this timer's trigger output then counts in step with it, and a preloaded offset between the two is kept.
- R7: A rising trigger edge in trigger or gated mode sets the trigger flag. The clear strobe resets the flag. When both happen in one cycle, the set wins.
- R8: The update-generate strobe loads 0 into the counter, with priority over a write and over counting.
- R9: A counter write loads the value while the enable is 0. While the enable is 1, the write is ignored and counting goes on.
- R10: With slave mode 3'b101 (gated mode), the enable follows the trigger level with a one-cycle lag. The counter holds while the enable is 0.
- R11: A further trigger edge while already enabled in trigger mode sets the flag again but does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | External trigger input |
| peer_trig | input | 1 | Trigger output of a peer timer |
| cfg_we | input | 1 | Load all mode fields |
| cfg_out_sel | input | 3 | Trigger output select |
| cfg_trig_sel | input | 3 | Trigger source select |
| cfg_slave_mode | input | 3 | Slave mode select |
| cfg_sync | input | 1 | Master/slave delay bit |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| upd_gen | input | 1 | Update generate, clears counter |
| flag_clr | input | 1 | Clears the trigger flag |
| count_o | output | W | Counter value |
| trig_out | output | 1 | Trigger output |
| run_en | output | 1 | Counter enable state |
| trig_flag | output | 1 | Trigger interrupt flag |

## Verification
The bench builds two chained instances with W = 8. At that width, wraparound comes within a few hundred cycles, so the bench checks it inside a single long run. Every slave preload offset from 0 to 255 is swept, and for each one the master/slave count difference is checked from the start edge onward. Gated mode is driven with pulse widths from 1 to 8, and the counter must accumulate exactly their sum.

// File: rtl/trig_sync_timer.sv
module trig_sync_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_in,
  input  logic         peer_trig,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_out_sel,
  input  logic [2:0]   cfg_trig_sel,
  input  logic [2:0]   cfg_slave_mode,
  input  logic         cfg_sync,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         upd_gen,
  input  logic         flag_clr,
  output logic [W-1:0] count_o,
  output logic         trig_out,
  output logic         run_en,
  output logic         trig_flag
);
  localparam logic [2:0] SEL_EXT  = 3'b100;
  localparam logic [2:0] SEL_PEER = 3'b001;
  localparam logic [2:0] MODE_GATE = 3'b101;
  localparam logic [2:0] MODE_TRIG = 3'b110;
  localparam logic [2:0] OUT_EN   = 3'b001;

  logic [2:0] out_sel_q, trig_sel_q, mode_q;
  logic       sync_q, trig_q, en_q, en_dly_q, flag_q;
  logic [W-1:0] cnt_q;

  wire trig = (trig_sel_q == SEL_EXT)  ? ext_in :
              (trig_sel_q == SEL_PEER) ? peer_trig : 1'b0;
  wire rise    = trig & ~trig_q;
  wire mode_on = (mode_q == MODE_TRIG) || (mode_q == MODE_GATE);
  wire step    = sync_q ? en_dly_q : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sel_q  <= '0;
      trig_sel_q <= '0;
      mode_q     <= '0;
      sync_q     <= 1'b0;
      trig_q     <= 1'b0;
      en_q       <= 1'b0;
      en_dly_q   <= 1'b0;
      flag_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (cfg_we) begin
        out_sel_q  <= cfg_out_sel;
        trig_sel_q <= cfg_trig_sel;
        mode_q     <= cfg_slave_mode;
        sync_q     <= cfg_sync;
      end
      trig_q   <= trig;
      en_dly_q <= en_q;
      if (mode_q == MODE_TRIG && rise) en_q <= 1'b1;
      else if (mode_q == MODE_GATE)    en_q <= trig;
      if (mode_on && rise) flag_q <= 1'b1;
      else if (flag_clr)   flag_q <= 1'b0;
      if (upd_gen)             cnt_q <= '0;
      else if (cnt_we && !en_q) cnt_q <= cnt_wdata;
      else if (step)           cnt_q <= cnt_q + W'(1);
    end
  end

  assign count_o   = cnt_q;
  assign run_en    = en_q;
  assign trig_flag = flag_q;
  assign trig_out  = (out_sel_q == OUT_EN) ? en_q : 1'b0;

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TRIG && en_q && !cfg_we) |=> en_q);
  assert_dead_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TRIG && trig_sel_q != SEL_EXT && trig_sel_q != SEL_PEER && !en_q && !cfg_we) |=> !en_q);
  assert_out_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel_q != OUT_EN) |-> !trig_out);
  assert_incr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && en_q && !upd_gen && !cfg_we) |=> cnt_q == $past(cnt_q) + W'(1));
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && rise) |=> flag_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_gen |=> cnt_q == '0);
  assert_gate_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_GATE && !trig && !cfg_we) |=> !en_q);
endmodule

// File: tb/trig_sync_timer_tb.sv
module trig_sync_timer_tb;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext = 1'b0, peer_a = 1'b0;
  logic m_cfg_we = 0, s_cfg_we = 0;
  logic [2:0] m_osel = 0, m_tsel = 0, m_mode = 0, s_osel = 0, s_tsel = 0, s_mode = 0;
  logic m_sync = 0, s_sync = 0;
  logic m_cwe = 0, s_cwe = 0, m_ug = 0, s_ug = 0, m_fclr = 0, s_fclr = 0;
  logic [W-1:0] m_cwd = 0, s_cwd = 0;
  logic [W-1:0] m_cnt, s_cnt;
  logic m_tout, s_tout, m_en, s_en, m_flag, s_flag;
  int tests = 0, fails = 0, exp_c = 0, total = 0;

  always #5 clk = ~clk;

  trig_sync_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext), .peer_trig(peer_a),
    .cfg_we(m_cfg_we), .cfg_out_sel(m_osel), .cfg_trig_sel(m_tsel),
    .cfg_slave_mode(m_mode), .cfg_sync(m_sync), .cnt_we(m_cwe), .cnt_wdata(m_cwd),
    .upd_gen(m_ug), .flag_clr(m_fclr), .count_o(m_cnt), .trig_out(m_tout),
    .run_en(m_en), .trig_flag(m_flag));

  trig_sync_timer #(.W(W)) u_peer (
    .clk(clk), .rst_n(rst_n), .ext_in(1'b0), .peer_trig(m_tout),
    .cfg_we(s_cfg_we), .cfg_out_sel(s_osel), .cfg_trig_sel(s_tsel),
    .cfg_slave_mode(s_mode), .cfg_sync(s_sync), .cnt_we(s_cwe), .cnt_wdata(s_cwd),
    .upd_gen(s_ug), .flag_clr(s_fclr), .count_o(s_cnt), .trig_out(s_tout),
    .run_en(s_en), .trig_flag(s_flag));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext = 0; peer_a = 0;
    m_cwe = 0; s_cwe = 0; m_ug = 0; s_ug = 0; m_fclr = 0; s_fclr = 0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic cfg_m(input logic [2:0] o, input logic [2:0] t, input logic [2:0] md, input logic sy);
    m_osel = o; m_tsel = t; m_mode = md; m_sync = sy; m_cfg_we = 1;
    step();
    m_cfg_we = 0;
  endtask

  task automatic cfg_s(input logic [2:0] o, input logic [2:0] t, input logic [2:0] md, input logic sy);
    s_osel = o; s_tsel = t; s_mode = md; s_sync = sy; s_cfg_we = 1;
    step();
    s_cfg_we = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 count", m_cnt, 0);
    check("R1 enable", m_en, 0);
    check("R1 flag", m_flag, 0);
    check("R1 trig out", m_tout, 0);

    // R2 R5: trigger mode, external source, no sync delay, long run through wrap
    cfg_m(3'b001, 3'b100, 3'b110, 1'b0);
    ext = 1; step();
    check("R2 enable set", m_en, 1);
    check("R4 out follows enable", m_tout, 1);
    check("R7 flag set", m_flag, 1);
    check("R5 first cycle", m_cnt, 0);
    ext = 0;
    exp_c = 0;
    for (int k = 0; k < 300; k++) begin
      step(); exp_c = (exp_c + 1) % M;
      check("R5 count/wrap", m_cnt, exp_c);
      check("R2 enable held", m_en, 1);
    end
    // R7 clear, R11 retrigger
    m_fclr = 1; step(); m_fclr = 0; exp_c = (exp_c + 1) % M;
    check("R7 flag cleared", m_flag, 0);
    ext = 1; step(); ext = 0; exp_c = (exp_c + 1) % M;
    check("R11 flag again", m_flag, 1);
    check("R11 no restart", m_cnt, exp_c);
    step(); exp_c = (exp_c + 1) % M;
    m_fclr = 1; ext = 1; step(); m_fclr = 0; ext = 0; exp_c = (exp_c + 1) % M;
    check("R7 set wins over clear", m_flag, 1);
    // R9 write ignored while enabled
    m_cwe = 1; m_cwd = 8'h55; step(); m_cwe = 0; exp_c = (exp_c + 1) % M;
    check("R9 write ignored when running", m_cnt, exp_c);
    // R8 update generate
    m_ug = 1; m_cwe = 1; m_cwd = 8'h33; step(); m_ug = 0; m_cwe = 0;
    check("R8 cleared", m_cnt, 0);
    step();
    check("R8 counts on", m_cnt, 1);

    // R3 source selection
    do_reset();
    cfg_m(3'b001, 3'b010, 3'b110, 1'b0);
    ext = 1; peer_a = 1; step(); step(); step();
    check("R3 unused code ignores inputs", m_en, 0);
    check("R3 flag untouched", m_flag, 0);
    ext = 0; peer_a = 0;
    cfg_m(3'b001, 3'b100, 3'b110, 1'b0);
    peer_a = 1; step(); step(); step();
    check("R3 peer ignored on ext select", m_en, 0);
    cfg_m(3'b001, 3'b001, 3'b110, 1'b0);
    step();
    check("R3 peer selected", m_en, 1);
    cfg_m(3'b000, 3'b001, 3'b110, 1'b0);
    check("R4 output off", m_tout, 0);
    check("R4 enable unaffected", m_en, 1);

    // R9 write while stopped, R8 clear
    do_reset();
    m_cwe = 1; m_cwd = 8'hA7; step(); m_cwe = 0;
    check("R9 load when stopped", m_cnt, 8'hA7);
    check("R9 still stopped", m_en, 0);
    m_ug = 1; step(); m_ug = 0;
    check("R8 clear when stopped", m_cnt, 0);

    // R6 chained sweep over every offset
    for (int k = 0; k < M; k++) begin
      do_reset();
      cfg_m(3'b001, 3'b100, 3'b110, 1'b1);
      cfg_s(3'b000, 3'b001, 3'b110, 1'b0);
      s_cwe = 1; s_cwd = W'(k); step(); s_cwe = 0;
      ext = 1; step(); ext = 0;
      check("R6 master enabled", m_en, 1);
      check("R6 slave not yet", s_en, 0);
      check("R6 master held", m_cnt, 0);
      step();
      check("R6 slave enabled", s_en, 1);
      check("R7 slave flag", s_flag, 1);
      check("R6 master delayed", m_cnt, 0);
      check("R6 slave held", s_cnt, k);
      for (int c = 1; c <= ((k == 200) ? 300 : 8); c++) begin
        step();
        check("R6 master count", m_cnt, c % M);
        check("R6 offset kept", (s_cnt - m_cnt) & (M - 1), k);
      end
    end

    // R10 gated mode with pulse widths 1..8
    do_reset();
    cfg_m(3'b001, 3'b100, 3'b101, 1'b0);
    total = 0;
    for (int L = 1; L <= 8; L++) begin
      ext = 1; step();
      check("R10 enable follows high", m_en, 1);
      for (int j = 1; j < L; j++) step();
      ext = 0; total += L;
      step(); step();
      check("R10 enable follows low", m_en, 0);
      check("R10 accumulated", m_cnt, total);
      step(); step();
      check("R10 holds while low", m_cnt, total);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule